// File: doc/BRIEF.md
# Timer DMA Burst Register Redirector

This block sits on the register bus of a timer and gives a DMA engine a single data port through which a run of consecutive timer registers can be read or written. A DMA control register sets two things: the register where the run starts, counted in words from the first timer control register, and how many transfers make up one burst. Each bus access that hits the data port is steered to the register at start offset plus a running index. The index then moves forward and returns to zero once the burst's transfers are used up. The DMA engine can therefore stream a block of registers without knowing their individual addresses.

The timer's own registers are modelled as a word-addressed store of 16-bit words. This store can also be reached directly at its own addresses. An input selects byte transfers. In that mode each 16-bit datum on the port covers two adjacent registers: the upper byte goes to the first register and the lower byte to the next. The burst still spans the programmed number of registers.

Top module: `tdb_burst_redirect`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x0000, the index is 0, and every storage word reads 0x0000.
- R2: The control register sits at byte address 0x48. It holds the start offset in bits 4:0 and the length code in bits 12:8. Bits 7:5 and 15:13 always read 0, and writes to them are ignored.
- R3: Storage words 0 to 17 are read and written directly at byte address 4×w. Address bits 1:0 are ignored. The data port sits at byte address 0x4C.
- R4: With byte mode low, a port access reads or writes the full 16 bits of storage word (offset + index), and the index then grows by 1.
- R5: A length code n gives n+1 transfers. A port access for which index + step reaches that count leaves the index at 0.
- R6: Length codes above 17 act as 17, which gives 18 transfers. The register still reads back the code as written.
- R7: A write to the control register sets the index to 0.
- R8: A port target at word 18 or above reads as 0 and drops writes, including writes that would land on the control or port words. The index still advances.
- R9: With byte mode high, a port write stores {8'h00, wdata[15:8]} in the target word and {8'h00, wdata[7:0]} in the next word, and the index grows by 2. The second store happens only while index+1 is below the transfer count.
- R10: With byte mode high, a port read returns {target[7:0], next[7:0]}. The low byte is 0 when the next word lies past the burst or outside storage. The index grows by 2.
- R11: The index changes only on a port access or a control write. Accesses to byte addresses 0x50 to 0xFC read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle while high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| byte_mode | input | 1 | Selects byte transfers on the data port |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |

## Verification
The critical overlap is the final transfer of a burst arriving in the same cycle as a suppressed access. This happens when the last target lies beyond storage, or when the second byte of a byte-mode transfer falls past the burst end. In that cycle the write must be dropped or the byte forced to zero, and the index must still wrap. The bench provokes this with directed bursts that start at offset 16 and with odd-length byte bursts, and it adds random offsets and lengths near the storage edge. It judges the result by reading storage directly afterwards and by checking where the next port access lands.

// File: rtl/tdb_pkg.sv
// Package tdb_pkg
// Shared field positions and access classes for the burst redirector.
// Assumes a 16-bit register bus with word-aligned registers.
package tdb_pkg;
    localparam int OFF_LSB  = 0;   // start offset field position
    localparam int LEN_LSB  = 8;   // length code field position
    localparam int FIELD_W  = 5;   // width of both fields

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STORE,
        ACC_CTRL,
        ACC_PORT,
        ACC_VOID
    } acc_kind_t;
endpackage

// File: rtl/tdb_ctrl_reg.sv
// Module tdb_ctrl_reg
// Holds the DMA control register (start offset, length code) and the
// running burst index. The index clears on a control write and wraps
// to zero once the clamped transfer count is reached.
// Assumes at most one access per cycle (write and port access exclusive).
module tdb_ctrl_reg #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 5,
    parameter int LEN_MAX = 17,
    parameter int CNT_W   = 5,
    parameter int OFF_LSB = 0,
    parameter int LEN_LSB = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               port_acc,
    input  logic               double_step,
    output logic [FIELD_W-1:0] start_off,
    output logic [FIELD_W-1:0] len_code,
    output logic [CNT_W-1:0]   burst_idx,
    output logic [CNT_W-1:0]   burst_cnt
);
    localparam logic [FIELD_W-1:0] LEN_CAP = FIELD_W'(LEN_MAX);

    logic [FIELD_W-1:0] len_eff;
    logic [CNT_W:0]     idx_sum;
    logic               idx_wrap;
    logic [CNT_W-1:0]   idx_next;

    // Capture offset and length fields; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_off <= '0;
            len_code  <= '0;
        end else if (ctrl_we) begin
            start_off <= wdata[OFF_LSB +: FIELD_W];
            len_code  <= wdata[LEN_LSB +: FIELD_W];
        end
    end

    // Clamp the length code and turn it into a transfer count.
    always_comb begin
        len_eff   = (len_code > LEN_CAP) ? LEN_CAP : len_code;
        burst_cnt = CNT_W'(len_eff) + CNT_W'(1);
    end

    // Work out the index after this access, wrapping at the count.
    always_comb begin
        idx_sum  = {1'b0, burst_idx} + (double_step ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
        idx_wrap = (idx_sum >= {1'b0, burst_cnt});
        idx_next = idx_wrap ? '0 : idx_sum[CNT_W-1:0];
    end

    // Update the running index on control writes and port accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_idx <= '0;
        end else if (ctrl_we) begin
            burst_idx <= '0;
        end else if (port_acc) begin
            burst_idx <= idx_next;
        end
    end
endmodule

// File: rtl/tdb_addr_gen.sv
// Module tdb_addr_gen
// Forms the primary and secondary redirect targets from offset and index,
// and flags whether each lands inside storage and inside the burst.
// Assumes TGT_W is wide enough for offset + index + 1 without overflow.
module tdb_addr_gen #(
    parameter int FIELD_W     = 5,
    parameter int CNT_W       = 5,
    parameter int TGT_W       = 6,
    parameter int STORE_WORDS = 18
) (
    input  logic [FIELD_W-1:0] start_off,
    input  logic [CNT_W-1:0]   burst_idx,
    input  logic [CNT_W-1:0]   burst_cnt,
    input  logic               byte_mode,
    output logic [TGT_W-1:0]   tgt_a,
    output logic [TGT_W-1:0]   tgt_b,
    output logic               a_ok,
    output logic               b_ok
);
    localparam logic [TGT_W-1:0] STORE_LIM = TGT_W'(STORE_WORDS);

    logic second_live;

    // Compute both targets and their validity.
    always_comb begin
        tgt_a       = TGT_W'(start_off) + TGT_W'(burst_idx);
        tgt_b       = tgt_a + TGT_W'(1);
        second_live = byte_mode && (({1'b0, burst_idx} + (CNT_W+1)'(1)) < {1'b0, burst_cnt});
        a_ok        = (tgt_a < STORE_LIM);
        b_ok        = second_live && (tgt_b < STORE_LIM);
    end
endmodule

// File: rtl/tdb_regfile.sv
// Module tdb_regfile
// Word-addressed register storage with two write ports and two
// combinational read ports. Out-of-range addresses read as zero.
// Assumes the two write ports never target the same word in one cycle.
module tdb_regfile #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 18,
    parameter int TGT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en,
    input  logic [TGT_W-1:0]  wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [TGT_W-1:0]  wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [TGT_W-1:0]  ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [TGT_W-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Store one word from whichever write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (wa_en && (wa_addr == TGT_W'(w))) begin
                mem[w] <= wa_data;
            end else if (wb_en && (wb_addr == TGT_W'(w))) begin
                mem[w] <= wb_data;
            end
        end
    end

    // Select read data for both ports, zero when nothing matches.
    always_comb begin
        ra_data = '0;
        rb_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (ra_addr == TGT_W'(w)) ra_data = mem[w];
            if (rb_addr == TGT_W'(w)) rb_data = mem[w];
        end
    end
endmodule

// File: rtl/tdb_burst_redirect.sv
// Module tdb_burst_redirect
// Top of the timer DMA burst redirector: decodes the bus, holds the DMA
// control register, and steers data-port accesses to storage words at
// offset + index, in word or byte transfer mode.
// Assumes one access per cycle, with read data used in the same cycle.
module tdb_burst_redirect #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int STORE_WORDS = 18,
    parameter int LEN_MAX     = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] bus_rdata
);
    import tdb_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam int TGT_W  = WORD_W;
    localparam int CNT_W  = $clog2(LEN_MAX + 2);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(STORE_WORDS);
    localparam logic [WORD_W-1:0] PORT_WORD = WORD_W'(STORE_WORDS + 1);

    logic [WORD_W-1:0]  word;
    acc_kind_t          kind;
    logic               ctrl_we;
    logic               port_acc;
    logic [FIELD_W-1:0] start_off;
    logic [FIELD_W-1:0] len_code;
    logic [CNT_W-1:0]   burst_idx;
    logic [CNT_W-1:0]   burst_cnt;
    logic [TGT_W-1:0]   tgt_a;
    logic [TGT_W-1:0]   tgt_b;
    logic               a_ok;
    logic               b_ok;
    logic               wa_en;
    logic [TGT_W-1:0]   wa_addr;
    logic [DATA_W-1:0]  wa_data;
    logic               wb_en;
    logic [DATA_W-1:0]  wb_data;
    logic [TGT_W-1:0]   ra_addr;
    logic [DATA_W-1:0]  ra_data;
    logic [DATA_W-1:0]  rb_data;
    logic [DATA_W-1:0]  ctrl_view;

    // Classify the current access by its word address.
    always_comb begin
        word = bus_addr[ADDR_W-1:2];
        if (!bus_sel)                                kind = ACC_NONE;
        else if (word < WORD_W'(STORE_WORDS))        kind = ACC_STORE;
        else if (word == CTRL_WORD)                  kind = ACC_CTRL;
        else if (word == PORT_WORD)                  kind = ACC_PORT;
        else                                         kind = ACC_VOID;
        ctrl_we  = (kind == ACC_CTRL) && bus_wr;
        port_acc = (kind == ACC_PORT);
    end

    tdb_ctrl_reg #(
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W),
        .LEN_MAX (LEN_MAX),
        .CNT_W   (CNT_W),
        .OFF_LSB (OFF_LSB),
        .LEN_LSB (LEN_LSB)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .wdata       (bus_wdata),
        .port_acc    (port_acc),
        .double_step (byte_mode),
        .start_off   (start_off),
        .len_code    (len_code),
        .burst_idx   (burst_idx),
        .burst_cnt   (burst_cnt)
    );

    tdb_addr_gen #(
        .FIELD_W     (FIELD_W),
        .CNT_W       (CNT_W),
        .TGT_W       (TGT_W),
        .STORE_WORDS (STORE_WORDS)
    ) u_agen (
        .start_off (start_off),
        .burst_idx (burst_idx),
        .burst_cnt (burst_cnt),
        .byte_mode (byte_mode),
        .tgt_a     (tgt_a),
        .tgt_b     (tgt_b),
        .a_ok      (a_ok),
        .b_ok      (b_ok)
    );

    // Route direct or redirected writes onto the two storage write ports.
    always_comb begin
        wa_en   = 1'b0;
        wa_addr = word;
        wa_data = bus_wdata;
        wb_en   = 1'b0;
        wb_data = {{HALF_W{1'b0}}, bus_wdata[HALF_W-1:0]};
        if (kind == ACC_STORE) begin
            wa_en = bus_wr;
        end else if (port_acc) begin
            wa_addr = tgt_a;
            wa_en   = bus_wr && a_ok;
            wb_en   = bus_wr && b_ok;
            if (byte_mode) wa_data = {{HALF_W{1'b0}}, bus_wdata[DATA_W-1:HALF_W]};
        end
        ra_addr = port_acc ? tgt_a : word;
    end

    tdb_regfile #(
        .DATA_W (DATA_W),
        .WORDS  (STORE_WORDS),
        .TGT_W  (TGT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (tgt_b),
        .wb_data (wb_data),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (tgt_b),
        .rb_data (rb_data)
    );

    // Assemble the control register view with reserved bits at zero.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[OFF_LSB +: FIELD_W] = start_off;
        ctrl_view[LEN_LSB +: FIELD_W] = len_code;
    end

    // Select read data according to the access class and transfer mode.
    always_comb begin
        unique case (kind)
            ACC_STORE: bus_rdata = ra_data;
            ACC_CTRL:  bus_rdata = ctrl_view;
            ACC_PORT: begin
                if (byte_mode)
                    bus_rdata = {(a_ok ? ra_data[HALF_W-1:0] : {HALF_W{1'b0}}),
                                 (b_ok ? rb_data[HALF_W-1:0] : {HALF_W{1'b0}})};
                else
                    bus_rdata = a_ok ? ra_data : '0;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tdb_burst_redirect_chk.sv
// Module tdb_burst_redirect_chk
// Assertion checker for the burst redirector, bound to the top module.
// Decodes the bus on its own and checks index motion and read-data rules.
// Assumes the top's default field layout (offset 4:0, length 12:8).
module tdb_burst_redirect_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int STORE_WORDS = 18,
    parameter int CNT_W       = 5,
    parameter int FIELD_W     = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               byte_mode,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [FIELD_W-1:0] start_off,
    input logic [CNT_W-1:0]   burst_idx,
    input logic [CNT_W-1:0]   burst_cnt
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] c_word;
    logic              c_port;
    logic              c_ctrl_rd;
    logic              c_ctrl_wr;
    logic [CNT_W:0]    c_sum;
    logic              c_wrap;
    logic [WORD_W:0]   c_tgt;

    // Independent decode of the access and its wrap condition.
    always_comb begin
        c_word    = bus_addr[ADDR_W-1:2];
        c_port    = bus_sel && (c_word == WORD_W'(STORE_WORDS + 1));
        c_ctrl_rd = bus_sel && !bus_wr && (c_word == WORD_W'(STORE_WORDS));
        c_ctrl_wr = bus_sel && bus_wr && (c_word == WORD_W'(STORE_WORDS));
        c_sum     = {1'b0, burst_idx} + (byte_mode ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
        c_wrap    = (c_sum >= {1'b0, burst_cnt});
        c_tgt     = (WORD_W+1)'(start_off) + (WORD_W+1)'(burst_idx);
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (burst_idx == '0));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl_rd |-> (bus_rdata[7:5] == 3'b000 && bus_rdata[15:13] == 3'b000));

    a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_port && !byte_mode && !c_wrap) |=> (burst_idx == $past(burst_idx) + CNT_W'(1)));

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (c_port && c_wrap) |=> (burst_idx == '0));

    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        burst_idx < burst_cnt);

    a_r7_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl_wr |=> (burst_idx == '0));

    a_r8_void_read: assert property (@(posedge clk) disable iff (!rst_n)
        (c_port && !bus_wr && !byte_mode && (c_tgt >= (WORD_W+1)'(STORE_WORDS))) |-> (bus_rdata == '0));

    a_r9_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_port && byte_mode && !c_wrap) |=> (burst_idx == $past(burst_idx) + CNT_W'(2)));

    a_r11_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_port && !c_ctrl_wr) |=> $stable(burst_idx));
endmodule

bind tdb_burst_redirect tdb_burst_redirect_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STORE_WORDS (STORE_WORDS),
    .CNT_W       (CNT_W),
    .FIELD_W     (tdb_pkg::FIELD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .byte_mode (byte_mode),
    .bus_rdata (bus_rdata),
    .start_off (start_off),
    .burst_idx (burst_idx),
    .burst_cnt (burst_cnt)
);

// File: tb/tdb_burst_redirect_bench.sv
`timescale 1ns/1ps
// Bench for tdb_burst_redirect: directed bursts plus seeded random traffic,
// checked against a behavioural model written from the requirements.
module tdb_burst_redirect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_mem [18];
    int m_off, m_len, m_idx;

    tdb_burst_redirect u_tdb_burst_redirect (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .byte_mode(byte_mode),
        .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_cnt();
        return ((m_len > 17) ? 17 : m_len) + 1;
    endfunction

    function automatic logic [15:0] m_word(int t);
        return (t < 18) ? m_mem[t] : 16'h0000;
    endfunction

    function automatic logic [15:0] m_read(logic [7:0] addr, bit bm);
        int w, t;
        logic [7:0] lo;
        w = int'(addr[7:2]);
        if (w < 18) return m_mem[w];
        if (w == 18) return {3'b000, m_len[4:0], 3'b000, m_off[4:0]};
        if (w != 19) return 16'h0000;
        t = m_off + m_idx;
        if (!bm) return m_word(t);
        lo = (m_idx + 1 < m_cnt()) ? m_word(t + 1)[7:0] : 8'h00;
        return {m_word(t)[7:0], lo};
    endfunction

    function automatic void m_update(bit wr, logic [7:0] addr, logic [15:0] d, bit bm);
        int w, t, nx;
        w = int'(addr[7:2]);
        if (w < 18 && wr) m_mem[w] = d;
        if (w == 18 && wr) begin
            m_off = int'(d[4:0]);
            m_len = int'(d[12:8]);
            m_idx = 0;
        end
        if (w == 19) begin
            t = m_off + m_idx;
            if (wr) begin
                if (!bm) begin
                    if (t < 18) m_mem[t] = d;
                end else begin
                    if (t < 18) m_mem[t] = {8'h00, d[15:8]};
                    if (m_idx + 1 < m_cnt() && t + 1 < 18) m_mem[t + 1] = {8'h00, d[7:0]};
                end
            end
            nx = m_idx + (bm ? 2 : 1);
            m_idx = (nx >= m_cnt()) ? 0 : nx;
        end
    endfunction

    // One bus access: drive at negedge, check read data, update model after the edge.
    task automatic acc(bit wr, logic [7:0] addr, logic [15:0] d, bit bm, string tag);
        logic [15:0] exp;
        exp = m_read(addr, bm);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = d; byte_mode = bm;
        #1;
        if (!wr) chk(tag, bus_rdata, exp);
        @(posedge clk);
        m_update(wr, addr, d, bm);
        #1 bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] sa(int w);
        return 8'(w * 4);
    endfunction

    initial begin
        for (int i = 0; i < 18; i++) m_mem[i] = '0;
        m_off = 0; m_len = 0; m_idx = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of control, storage and index
        acc(0, 8'h48, 0, 0, "R1 ctrl");
        acc(0, sa(5), 0, 0, "R1 store");
        acc(0, 8'h4C, 0, 0, "R1 port");

        // R3: direct storage access, low address bits ignored
        acc(1, 8'h0E, 16'hBEEF, 0, "R3");
        acc(0, sa(3), 0, 0, "R3");
        chk("R3 literal", m_mem[3], 16'hBEEF);

        // R2: reserved bits dropped
        acc(1, 8'h48, 16'hE2E0 | 16'h0102, 0, "R2");
        acc(0, 8'h48, 0, 0, "R2");

        // R4 / R5: word burst of 3 from offset 0, fourth write wraps
        acc(1, 8'h48, 16'h0200, 0, "R5");
        acc(1, 8'h4C, 16'h1111, 0, "R4");
        acc(1, 8'h4C, 16'h2222, 0, "R4");
        acc(1, 8'h4C, 16'h3333, 0, "R4");
        acc(1, 8'h4C, 16'h4444, 0, "R5");
        acc(0, sa(0), 0, 0, "R5 wrap landed on word 0");
        acc(0, sa(2), 0, 0, "R4");

        // R6: code 31 clamps to 18 transfers
        acc(1, 8'h48, 16'h1F00, 0, "R6");
        acc(0, 8'h48, 0, 0, "R6 readback");
        for (int i = 0; i < 18; i++) acc(1, 8'h4C, 16'(i + 16'h0A00), 0, "R6");
        acc(1, 8'h4C, 16'h5555, 0, "R6");
        acc(0, sa(0), 0, 0, "R6 wrap");
        acc(0, sa(17), 0, 0, "R6 last");
        chk("R6 literal", m_mem[17], 16'h0A11);

        // R7: control write resets index
        acc(1, 8'h48, 16'h0504, 0, "R7");
        acc(1, 8'h4C, 16'h7001, 0, "R7");
        acc(1, 8'h4C, 16'h7002, 0, "R7");
        acc(1, 8'h48, 16'h0504, 0, "R7");
        acc(0, 8'h4C, 0, 0, "R7 restart at offset");

        // R8: burst crossing storage end; last transfer both void and wrapping
        acc(1, 8'h48, 16'h0310, 0, "R8");
        acc(1, 8'h4C, 16'h8016, 0, "R8");
        acc(1, 8'h4C, 16'h8017, 0, "R8");
        acc(1, 8'h4C, 16'h8018, 0, "R8");
        acc(1, 8'h4C, 16'h8019, 0, "R8");
        acc(0, 8'h48, 0, 0, "R8 ctrl untouched");
        acc(0, 8'h4C, 0, 0, "R8 wrapped to word 16");
        acc(0, 8'h4C, 0, 0, "R8");
        acc(0, 8'h4C, 0, 0, "R8 void read");

        // R9 / R10: odd byte burst of 3 at offset 4
        acc(1, sa(7), 16'h7777, 0, "R9");
        acc(1, 8'h48, 16'h0204, 0, "R9");
        acc(1, 8'h4C, 16'hA1B2, 1, "R9");
        acc(1, 8'h4C, 16'hC3D4, 1, "R9");
        acc(0, sa(4), 0, 0, "R9");
        acc(0, sa(5), 0, 0, "R9");
        acc(0, sa(6), 0, 0, "R9");
        acc(0, sa(7), 0, 0, "R9 beyond burst untouched");
        chk("R9 literal", m_mem[6], 16'h00C3);
        acc(0, 8'h4C, 0, 1, "R10");
        acc(0, 8'h4C, 0, 1, "R10 low byte zero past burst");
        acc(0, 8'h4C, 0, 1, "R10 wrapped");

        // R11: unmapped space and idle bus
        acc(1, 8'hF0, 16'hFFFF, 0, "R11");
        acc(0, 8'hF0, 0, 0, "R11");
        repeat (3) @(posedge clk);
        acc(0, 8'h4C, 0, 1, "R11 index held");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) begin
                acc(1, 8'h48, {3'($urandom), 5'($urandom), 3'($urandom),
                               5'($urandom_range(0, 20))}, 0, "R2 rnd");
            end else if (op <= 5) begin
                acc(1'($urandom), 8'h4C, 16'($urandom), 1'($urandom),
                    "R4/R8/R9/R10 rnd port");
            end else if (op <= 8) begin
                acc(1'($urandom), sa($urandom_range(0, 17)), 16'($urandom), 0, "R3 rnd");
            end else begin
                acc(1'($urandom), sa($urandom_range(18, 63)), 16'($urandom), 0, "R11 rnd");
            end
        end
        for (int w = 0; w < 18; w++) acc(0, sa(w), 0, 0, "R3 final sweep");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule